// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a processor reach a small bank of byte-wide configuration registers through a single 32-bit control word. The host writes one packed word that carries a bank reset-release flag, a write strobe, a register address and a data byte. It reads the same word back. The low byte of that readback always holds the contents of the register the address field currently selects.

A write takes three host accesses. The host sets address and data with the strobe clear, then sets the strobe, then clears it again. The rising edge of the stored strobe bit commits the data byte exactly once. A read needs no strobe: the host writes the address, waits one clock, and takes the low byte of the readback. While the release flag is 0 the whole bank is held at zero. Only the system reset clears the control word itself.

Top module: `ind_reg_bridge`

## Requirements
- R1: After system reset (rst_n low) the readback word host_rdata is 0x0000_0000.
- R2: A host write stores bit 28 (bank release), bit 24 (strobe), bits 20:16 (address) and bits 15:8 (data). Readback returns those bits exactly as last written, bits 31:29, 27:25 and 23:21 read 0, and host-written values in bits 7:0 are discarded.
- R3: When the stored strobe bit goes from 0 to 1 while bit 28 is 1, the stored data byte is committed into the register at the stored address, for any address 0 to 24.
- R4: Keeping the strobe at 1 while the data field changes commits nothing further. Only a new 0-to-1 transition writes again.
- R5: One clock after a host write, bits 7:0 of host_rdata hold the register selected by the new address field. This holds with the strobe clear.
- R6: Strobed writes to addresses 25 to 31 change no register, and reads of those addresses return 0x00.
- R7: While bit 28 is 0, every register reads 0x00 and strobes are ignored. Registers stay 0x00 after release until they are written again.
- R8: Clearing bit 28 does not clear the control word. Its readback fields still show the last host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_we | input | 1 | Single-cycle host write enable for the control word |
| host_wdata | input | 32 | Packed control word written by the host |
| host_rdata | output | 32 | Control word readback with the selected register in bits 7:0 |

## Verification
A corrupted bank entry is invisible until its address is selected. It then shows in the low readback byte one clock after the address write, so the bench selects every address 0 to 31 in turn after a full write sweep. A spurious or repeated strobe edge shows as a register holding a later data byte than the one present at the rising edge. A leak through the reset hold shows as a nonzero byte on the first read after release. A stale control field shows at once in the upper readback bits, on the next read after any host write.

// File: rtl/irb_pkg.sv
package irb_pkg;
   localparam int ADDR_W    = 5;
   localparam int DATA_W    = 8;
   localparam int REL_BIT   = 28;
   localparam int STB_BIT   = 24;
   localparam int ADDR_LSB  = 16;
   localparam int WDATA_LSB = 8;

   typedef struct packed {
      logic              rel;
      logic              stb;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] wdata;
   } ctl_t;
endpackage

// File: rtl/irb_ctl_word.sv
module irb_ctl_word
   import irb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [31:0] host_wdata,
   output ctl_t        ctl
);
   logic unused_hw;
   assign unused_hw = ^{host_wdata[31:REL_BIT+1], host_wdata[REL_BIT-1:STB_BIT+1],
                        host_wdata[STB_BIT-1:ADDR_LSB+ADDR_W], host_wdata[WDATA_LSB-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (host_we) begin
         ctl.rel   <= host_wdata[REL_BIT];
         ctl.stb   <= host_wdata[STB_BIT];
         ctl.addr  <= host_wdata[ADDR_LSB +: ADDR_W];
         ctl.wdata <= host_wdata[WDATA_LSB +: DATA_W];
      end
   end

   // R8: the word changes only on a host write
   a_r8_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !host_we |=> $stable(ctl));
   // R2: the address field follows the host word
   a_r2_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> ctl.addr == $past(host_wdata[ADDR_LSB +: ADDR_W]));
endmodule

// File: rtl/irb_strobe_edge.sv
module irb_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic enable,
   output logic pulse
);
   logic stb_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_prev <= 1'b0;
      else        stb_prev <= stb;
   end

   assign pulse = stb & ~stb_prev & enable;

   // R4: a held strobe yields a single commit pulse
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/irb_reg_bank.sv
module irb_reg_bank
   import irb_pkg::*;
#(
   parameter int NUM_REGS = 25,
   parameter bit RD_PIPE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

   logic [DATA_W-1:0] mem [NUM_REGS];
   logic              rd_hit;
   logic [DATA_W-1:0] rd_sel;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (!run)
            mem[g] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(g))
            mem[g] <= wr_data;
      end

      // R3: a commit lands in the addressed entry
      a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && run && wr_addr == ADDR_W'(g)) |=> mem[g] == $past(wr_data));
      // R7: a held bank is cleared
      a_r7_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> mem[g] == '0);
   end

   assign rd_hit = {1'b0, rd_addr} < LIMIT;
   assign rd_sel = rd_hit ? mem[rd_addr] : '0;

   if (RD_PIPE) begin : g_rd_pipe
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_sel;
      end
      assign rd_data = rd_q;

      // R5: readback follows the selected entry one clock later
      a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, rd_addr} < LIMIT) |=> rd_data == $past(mem[rd_addr]));
      // R6: addresses past the bank read as zero
      a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, rd_addr} >= LIMIT) |=> rd_data == '0);
   end else begin : g_rd_comb
      assign rd_data = rd_sel;
   end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
   import irb_pkg::*;
#(
   parameter int NUM_REGS = 25,
   parameter bit RD_PIPE  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("NUM_REGS out of range for the address field");
   end

   ctl_t              ctl;
   logic              wr_pulse;
   logic [DATA_W-1:0] rd_byte;

   irb_ctl_word u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_wdata (host_wdata),
      .ctl        (ctl)
   );

   irb_strobe_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (ctl.stb),
      .enable (ctl.rel),
      .pulse  (wr_pulse)
   );

   irb_reg_bank #(.NUM_REGS(NUM_REGS), .RD_PIPE(RD_PIPE)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl.rel),
      .wr_en   (wr_pulse),
      .wr_addr (ctl.addr),
      .wr_data (ctl.wdata),
      .rd_addr (ctl.addr),
      .rd_data (rd_byte)
   );

   always_comb begin
      host_rdata                           = '0;
      host_rdata[REL_BIT]                  = ctl.rel;
      host_rdata[STB_BIT]                  = ctl.stb;
      host_rdata[ADDR_LSB +: ADDR_W]       = ctl.addr;
      host_rdata[WDATA_LSB +: DATA_W]      = ctl.wdata;
      host_rdata[DATA_W-1:0]               = rd_byte;
   end
endmodule

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;
   logic [7:0] model [32];

   always #10 clk = ~clk;

   ind_reg_bridge u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [31:0] mk(input logic rel, input logic stb,
                                      input logic [4:0] a, input logic [7:0] d);
      return {3'b0, rel, 3'b0, stb, 3'b0, a, d, 8'h00};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] w);
      @(negedge clk); host_we = 1'b1; host_wdata = w;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic wreg(input logic [4:0] a, input logic [7:0] d);
      wr(mk(1, 0, a, d)); wr(mk(1, 1, a, d)); wr(mk(1, 0, a, d)); settle();
      if (a < 25) model[a] = d;
   endtask

   task automatic rdchk(input string req, input logic rel, input logic [4:0] a);
      wr(mk(rel, 0, a, 8'h00)); settle();
      chk(req, {24'h0, host_rdata[7:0]}, {24'h0, (a < 25) ? model[a] : 8'h00});
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R1", host_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", host_rdata, 32'h0);

      // R2 / R5: fields read back, bank starts at zero
      wr(mk(1, 0, 5'd3, 8'hC4)); settle();
      chk("R2", host_rdata, mk(1, 0, 5'd3, 8'hC4));

      // R3 / R6: write every address, then read every address (R5)
      for (int a = 0; a < 32; a++) wreg(5'(a), 8'((a * 37 + 11) & 8'hFF));
      for (int a = 0; a < 32; a++) rdchk((a < 25) ? "R3" : "R6", 1'b1, 5'(a));

      // R4: held strobe with changing data commits once
      wr(mk(1, 0, 5'd5, 8'hAA)); wr(mk(1, 1, 5'd5, 8'hAA));
      wr(mk(1, 1, 5'd5, 8'h55)); wr(mk(1, 1, 5'd5, 8'h33)); settle();
      chk("R4", {24'h0, host_rdata[7:0]}, 32'h0000_00AA);
      wr(mk(1, 0, 5'd5, 8'h66)); wr(mk(1, 1, 5'd5, 8'h66)); wr(mk(1, 0, 5'd5, 8'h66));
      model[5] = 8'h66;
      rdchk("R4", 1'b1, 5'd5);

      // R2 / R6: all-ones word, low byte discarded, addr 31 ignored
      wr(32'hFFFF_FFFF); settle();
      chk("R2", host_rdata, 32'h111F_FF00);
      wr(mk(1, 0, 5'd31, 8'h00));
      rdchk("R6", 1'b1, 5'd24);

      // R7 / R8: hold bank in reset
      wr(mk(0, 0, 5'd2, 8'h77)); settle();
      chk("R8", host_rdata, mk(0, 0, 5'd2, 8'h77));
      wr(mk(0, 1, 5'd2, 8'h77)); wr(mk(0, 0, 5'd2, 8'h77)); settle();
      chk("R7", {24'h0, host_rdata[7:0]}, 32'h0);
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      rdchk("R7", 1'b1, 5'd2);
      rdchk("R7", 1'b1, 5'd7);
      rdchk("R7", 1'b1, 5'd0);

      // R3 boundary after release
      wreg(5'd24, 8'h5A);
      rdchk("R3", 1'b1, 5'd24);
      wreg(5'd0, 8'hFF);
      rdchk("R3", 1'b1, 5'd0);
      rdchk("R5", 1'b1, 5'd24);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog got=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule